// File: doc/BRIEF.md
# Dual-Rail Handshake Register Stage

This block is one register stage of a dual-rail, delay-insensitive pipeline, modelled as synchronous logic. Each logical bit travels on a pair of rails. A pair is either empty (no value yet) or holds exactly one value, 0 or 1. Words move through the pipeline as alternating waves: a full data wave, then a full empty wave. The empty wave separates one data set from the next.

Each bit of the stage is steered by the next stage's request input. While the request is high, the bit accepts a data code from the previous stage. While it is low, the bit accepts the empty code. Once a bit has taken a value, it keeps it until the opposite kind of wave is both requested and present. A completion detector looks at the whole stored word and drives an acknowledge output back to the previous stage. The acknowledge is high (asking for data) once every bit is empty. It is low (asking for empty) once every bit holds data. While the word is only partly filled or partly drained, the acknowledge keeps its value. The result is a four-phase handshake whose pace follows when waves actually complete, not a fixed worst-case period. An input pair carrying both rails high is an illegal code: it is never stored, and it raises an error flag.

Top module: `dr_latch_stage`

## Requirements
- R1: Pair i of every word sits at bits [2i+1:2i]. Code 2'b00 means empty, 2'b01 means logical 0, 2'b10 means logical 1, and 2'b11 is illegal.
- R2: While the synchronous reset `rst` is high at a clock edge, after that edge `rail_out` is all 2'b00, `ack_out` is 1 and `code_err` is 0.
- R3: A stored pair that is empty, with `req_in` high and a data code (01 or 10) on its input pair, holds that code after the next edge.
- R4: A stored pair holding data, with `req_in` low and 2'b00 on its input pair, is 2'b00 after the next edge.
- R5: A stored pair holding data keeps its code in every other case, including a different data code on its input, or an empty input while `req_in` is high.
- R6: A stored empty pair stays empty in every other case, including a data input while `req_in` is low.
- R7: In the same cycle that `rail_out` changes, `ack_out` becomes 1 if every stored pair is empty and 0 if every stored pair holds data. Otherwise it keeps its previous value.
- R8: An input pair of 2'b11 is never stored. `code_err` is 1 after any edge at which some input pair was 2'b11, and 0 after an edge at which none was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the handshake |
| rst | input | 1 | Synchronous active-high reset |
| rail_in | input | 2*WIDTH | Dual-rail word from the previous stage |
| req_in | input | 1 | Request from the next stage: 1 asks for data, 0 asks for empty |
| rail_out | output | 2*WIDTH | Stored dual-rail word |
| ack_out | output | 1 | Completion acknowledge to the previous stage |
| code_err | output | 1 | An illegal 2'b11 pair was seen at the last edge |

## Verification
Two things can happen at the same clock edge: the last missing pair of a wave is captured, and the acknowledge flips. Because of this, the bench brings a wave in over several cycles and checks that the acknowledge holds while the word is mixed and turns in exactly the cycle the final pair lands. The illegal-code flag can also rise at the same edge where the other pairs are being captured. Directed steps put a 2'b11 next to valid data codes and check that the neighbouring pairs are stored, the illegal pair stays empty, the flag rises and the acknowledge does not flip. Random steps, including a mode where the request follows the acknowledge, are judged cycle by cycle against a reference model computed in the bench.

// File: rtl/ncl_stage_pkg.sv
package ncl_stage_pkg;

    typedef enum logic [1:0] {
        RAIL_NULL = 2'b00,
        RAIL_ZERO = 2'b01,
        RAIL_ONE  = 2'b10,
        RAIL_BAD  = 2'b11
    } rail_e;

    function automatic logic rail_is_data(input logic [1:0] r);
        return (r == 2'b01) || (r == 2'b10);
    endfunction

    function automatic logic rail_is_null(input logic [1:0] r);
        return r == 2'b00;
    endfunction

    // Hysteretic per-pair update: fill only on request-for-data, drain only on request-for-empty.
    function automatic rail_e rail_step(input rail_e cur, input logic [1:0] nin, input logic req);
        rail_e res;
        res = cur;
        if (cur == RAIL_NULL) begin
            if (req && rail_is_data(nin))
                res = rail_e'(nin);
        end else begin
            if (!req && rail_is_null(nin))
                res = RAIL_NULL;
        end
        return res;
    endfunction

endpackage

// File: rtl/rail_cell.sv
module rail_cell
    import ncl_stage_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pair_in,
    input  logic       req,
    output logic [1:0] pair_q,
    output logic [1:0] pair_nxt,
    output logic       pair_bad
);

    rail_e cur_q;
    rail_e nxt_c;

    always_comb nxt_c = rail_step(cur_q, pair_in, req);

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RAIL_NULL;
        else     cur_q <= nxt_c;
    end

    assign pair_q   = cur_q;
    assign pair_nxt = nxt_c;
    assign pair_bad = (pair_in == 2'b11);

    // R3
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == RAIL_NULL && req && rail_is_data(pair_in)) |=> (pair_q == $past(pair_in)));

    // R4
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_is_data(cur_q) && !req && pair_in == 2'b00) |=> (pair_q == 2'b00));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_is_data(cur_q) && !(!req && pair_in == 2'b00)) |=> $stable(pair_q));

    // R6
    null_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q == RAIL_NULL && !(req && rail_is_data(pair_in))) |=> (pair_q == 2'b00));

    // R8
    never_bad_chk: assert property (@(posedge clk) disable iff (rst)
        pair_q != 2'b11);

endmodule

// File: rtl/compl_detect.sv
module compl_detect #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] word_nxt,
    input  logic [2*WIDTH-1:0] word_q,
    output logic               ack
);
    import ncl_stage_pkg::*;

    logic nxt_all_null, nxt_all_data;
    logic cur_all_null, cur_all_data;
    logic ack_q;

    always_comb begin
        nxt_all_null = 1'b1;
        nxt_all_data = 1'b1;
        cur_all_null = 1'b1;
        cur_all_data = 1'b1;
        for (int i = 0; i < WIDTH; i++) begin
            nxt_all_null &= rail_is_null(word_nxt[2*i +: 2]);
            nxt_all_data &= rail_is_data(word_nxt[2*i +: 2]);
            cur_all_null &= rail_is_null(word_q[2*i +: 2]);
            cur_all_data &= rail_is_data(word_q[2*i +: 2]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               ack_q <= 1'b1;
        else if (nxt_all_null) ack_q <= 1'b1;
        else if (nxt_all_data) ack_q <= 1'b0;
    end

    assign ack = ack_q;

    // R7
    ack_null_chk: assert property (@(posedge clk) disable iff (rst)
        cur_all_null |-> ack);

    // R7
    ack_data_chk: assert property (@(posedge clk) disable iff (rst)
        cur_all_data |-> !ack);

    // R7
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cur_all_null && !cur_all_data) |-> $stable(ack));

endmodule

// File: rtl/dr_latch_stage.sv
module dr_latch_stage #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*WIDTH-1:0] rail_in,
    input  logic               req_in,
    output logic [2*WIDTH-1:0] rail_out,
    output logic               ack_out,
    output logic               code_err
);

    localparam int RAILS = 2 * WIDTH;

    logic [RAILS-1:0] word_nxt;
    logic [WIDTH-1:0] bad_vec;
    logic             err_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_pair
        rail_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .pair_in  (rail_in[2*g +: 2]),
            .req      (req_in),
            .pair_q   (rail_out[2*g +: 2]),
            .pair_nxt (word_nxt[2*g +: 2]),
            .pair_bad (bad_vec[g])
        );
    end

    compl_detect #(.WIDTH(WIDTH)) u_done (
        .clk      (clk),
        .rst      (rst),
        .word_nxt (word_nxt),
        .word_q   (rail_out),
        .ack      (ack_out)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= |bad_vec;
    end

    assign code_err = err_q;

    // R2
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rail_out == '0 && ack_out && !code_err));

    // R8
    err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|bad_vec) |=> code_err);

endmodule

// File: tb/dr_latch_stage_tb_top.sv
module dr_latch_stage_tb_top;

    localparam int  W          = 8;
    localparam time CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst;
    logic [2*W-1:0] rail_in;
    logic           req_in;
    logic [2*W-1:0] rail_out;
    logic           ack_out;
    logic           code_err;

    logic [2*W-1:0] m_q;
    logic           m_ack;
    logic           m_err;
    int             vectors;
    int             miscompares;

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_latch_stage #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .rail_in  (rail_in),
        .req_in   (req_in),
        .rail_out (rail_out),
        .ack_out  (ack_out),
        .code_err (code_err)
    );

    function automatic logic [2*W-1:0] ref_word(input logic [2*W-1:0] q,
                                                input logic [2*W-1:0] d, input logic k);
        logic [2*W-1:0] r;
        r = q;
        for (int i = 0; i < W; i++) begin
            if (q[2*i +: 2] == 2'b00) begin
                if (k && (d[2*i +: 2] == 2'b01 || d[2*i +: 2] == 2'b10))
                    r[2*i +: 2] = d[2*i +: 2];
            end else if (!k && d[2*i +: 2] == 2'b00) begin
                r[2*i +: 2] = 2'b00;
            end
        end
        return r;
    endfunction

    function automatic logic ref_ack(input logic [2*W-1:0] q, input logic prev);
        logic an, ad;
        an = 1'b1;
        ad = 1'b1;
        for (int i = 0; i < W; i++) begin
            an &= (q[2*i +: 2] == 2'b00);
            ad &= (q[2*i +: 2] == 2'b01 || q[2*i +: 2] == 2'b10);
        end
        return an ? 1'b1 : (ad ? 1'b0 : prev);
    endfunction

    function automatic logic any_bad(input logic [2*W-1:0] d);
        logic b;
        b = 1'b0;
        for (int i = 0; i < W; i++) b |= (d[2*i +: 2] == 2'b11);
        return b;
    endfunction

    // Full data word: bit value 1 -> 2'b10, value 0 -> 2'b01; mask selects pairs carrying data.
    function automatic logic [2*W-1:0] data_word(input logic [W-1:0] bits, input logic [W-1:0] mask);
        logic [2*W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++)
            if (mask[i]) r[2*i +: 2] = bits[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic logic [1:0] rand_pair();
        int v;
        v = $urandom_range(0, 15);
        if (v < 5)  return 2'b00;
        if (v < 10) return 2'b01;
        if (v < 15) return 2'b10;
        return 2'b11;
    endfunction

    task automatic apply(input logic r, input logic [2*W-1:0] d, input logic k, input string tag);
        @(negedge clk);
        rst     = r;
        rail_in = d;
        req_in  = k;
        if (r) begin
            m_q   = '0;
            m_ack = 1'b1;
            m_err = 1'b0;
        end else begin
            m_q   = ref_word(m_q, d, k);
            m_ack = ref_ack(m_q, m_ack);
            m_err = any_bad(d);
        end
        @(posedge clk);
        #1;
        vectors++;
        if (rail_out !== m_q || ack_out !== m_ack || code_err !== m_err) begin
            miscompares++;
            $display("FAIL %s: rail_out=%h ack_out=%b code_err=%b expected rail_out=%h ack_out=%b code_err=%b",
                     tag, rail_out, ack_out, code_err, m_q, m_ack, m_err);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: expired, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [2*W-1:0] d;
        vectors     = 0;
        miscompares = 0;
        m_q         = '0;
        m_ack       = 1'b1;
        m_err       = 1'b0;
        rst         = 1'b1;
        rail_in     = '0;
        req_in      = 1'b1;
        void'($urandom(32'd20240611));

        // R2: reset state
        apply(1'b1, '0, 1'b1, "R2");
        apply(1'b1, data_word(8'hFF, 8'hFF), 1'b1, "R2");

        // R7: half a data wave, acknowledge must hold high
        apply(1'b0, data_word(8'hA5, 8'h0F), 1'b1, "R7");
        // R3 / R7: wave completes, acknowledge drops in the same cycle
        apply(1'b0, data_word(8'hA5, 8'hFF), 1'b1, "R3");
        // R1: mixed 01/10 codes stored as given
        apply(1'b0, data_word(8'hA5, 8'hFF), 1'b1, "R1");
        // R5: different data presented while holding
        apply(1'b0, data_word(8'h5A, 8'hFF), 1'b1, "R5");
        // R5: empty input while request is high
        apply(1'b0, '0, 1'b1, "R5");
        // R5: request low but input still data
        apply(1'b0, data_word(8'h5A, 8'hFF), 1'b0, "R5");
        // R4 / R7: partial drain, acknowledge holds low
        apply(1'b0, data_word(8'h5A, 8'hF0), 1'b0, "R4");
        // R4: drain completes, acknowledge rises
        apply(1'b0, '0, 1'b0, "R4");
        // R6: data input while request low is ignored
        apply(1'b0, data_word(8'h33, 8'hFF), 1'b0, "R6");
        // R6: request high but empty input
        apply(1'b0, '0, 1'b1, "R6");
        // R8: illegal pair 0 alongside valid data on the others
        d = data_word(8'hC3, 8'hFE);
        d[1:0] = 2'b11;
        apply(1'b0, d, 1'b1, "R8");
        // R8: flag clears, last pair fills, acknowledge drops
        apply(1'b0, data_word(8'hC3, 8'hFF), 1'b1, "R8");
        // R2: reset with data stored
        apply(1'b1, data_word(8'h0F, 8'hFF), 1'b0, "R2");

        // R3/R4/R5/R6/R8: free random stimulus
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < W; i++) d[2*i +: 2] = rand_pair();
            apply(1'b0, d, 1'($urandom_range(0, 1)), "R3/R4/R5/R6/R8 random");
        end

        // R7: request follows acknowledge, waves arrive pair by pair
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] mask;
            mask = W'($urandom);
            if (m_ack) d = data_word(W'($urandom), mask | (($urandom_range(0, 3) == 0) ? '1 : '0));
            else       d = data_word(W'($urandom), mask & (($urandom_range(0, 3) == 0) ? '0 : '1));
            apply(1'b0, d, m_ack, "R7 handshake");
        end

        // R2: reset mid-run
        apply(1'b1, data_word(8'h99, 8'hFF), 1'b1, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule